// File: doc/BRIEF.md
# T1 Test Pattern Generator

This block produces the serial payload bit stream used to exercise a T1 line. A five-bit selector picks one pattern: a constant level, a repeating density-stress word, one of five maximal-length pseudo-random sequences, a quasi-random sequence with limited zero runs, or one of six patterns written through a small load port. Each clock on which `bit_en` is high moves the chosen pattern on by one bit. That bit appears on the registered output `bit_out`, and the `invert` control can complement it.

A change of selector restarts the chosen pattern from its first bit on the same enabled clock. A write to the user slot currently selected restarts that pattern from its first bit on the first enabled clock after the write. Each generator holds its own state, so the output never carries a leftover part of a previous pattern.

Top module: `t1_pattern_gen`

## Requirements
- R1: While `rst` is high, and after it until the first enabled clock, `bit_out` is 0.
- R2: Selector code 0 emits all zeros and code 1 emits all ones.
- R3: Codes 2, 3 and 4 repeat the words 0x40 (8 bits, one 1), 0x42 (8 bits, two 1s) and 0x440004 (24 bits, three 1s, a 15-zero run). Each word is sent MSB first.
- R4: Codes 5 to 9 emit PRBS of orders 9, 11, 15, 20 and 23 with feedback x^9+x^5+1, x^11+x^9+1, x^15+x^14+1, x^20+x^3+1 and x^23+x^18+1. The first N bits after a restart are ones and every later bit satisfies b[k] = b[k-N] xor b[k-T].
- R5: Code 10 runs the same recurrence with N=20 and T=17. An emitted bit is forced to 1 whenever the 14 bits emitted before it since the restart were all 0, so no zero run exceeds 14.
- R6: When `invert` is high at an enabled clock, the emitted bit is the complement of the pattern bit.
- R7: A write with `up_we` high and `up_idx` 0 to 5 stores `up_data` and the length code `up_len` in that user slot. A length code above 23 is stored as 23. A write with `up_idx` 6 or 7 changes nothing.
- R8: Codes 11 to 16 play user slots 0 to 5. A slot with length code c repeats `up_data[c:0]`, starting at bit c.
- R9: `bit_out` changes only on clocks where `bit_en` is high.
- R10: The first enabled clock with a selector value different from the one used at the previous enabled clock emits bit 0 of the new pattern.
- R11: A write to the slot currently selected makes the first enabled clock after the write cycle emit bit 0 of the new contents. An enabled clock in the same cycle as the write still uses the old contents.
- R12: Selector codes 17 to 31 emit zeros (before inversion).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Advance the pattern by one bit |
| pat_sel | input | 5 | Pattern selector code |
| invert | input | 1 | Complement the emitted bit |
| up_we | input | 1 | User pattern write strobe |
| up_idx | input | 3 | User slot index |
| up_len | input | 5 | Pattern length minus one |
| up_data | input | 24 | User pattern bits, last sent in bit 0 |
| bit_out | output | 1 | Registered serial pattern bit |

## Verification
Two events can fall in the same cycle: an enabled clock and a write to the slot that is playing. The bench drives `up_we` and `bit_en` together while a user pattern runs mid-word. The reference model must then show the old contents at the current position, followed by a restart at bit 0 of the new contents on the next enabled clock. The bench also changes the selector on an enabled clock mid-word and with `bit_en` gated. A cycle-exact model built on the recurrences (not on shift registers) judges every clock.

// File: rtl/t1pg_pkg.sv
package t1pg_pkg;
  localparam int SEL_W      = 5;
  localparam int CODE_ZEROS = 0;
  localparam int CODE_ONES  = 1;
  localparam int CODE_WORD0 = 2;
  localparam int NUM_WORDS  = 3;
  localparam int CODE_LFSR0 = 5;
  localparam int NUM_LFSR   = 6;
  localparam int USER_BASE  = 11;
  localparam int QRSS_IDX   = 5;
  localparam int QRSS_ZMAX  = 14;

  function automatic int lfsr_order(input int idx);
    case (idx)
      0: return 9;
      1: return 11;
      2: return 15;
      3: return 20;
      4: return 23;
      default: return 20;
    endcase
  endfunction

  function automatic int lfsr_tap(input int idx);
    case (idx)
      0: return 5;
      1: return 9;
      2: return 14;
      3: return 3;
      4: return 18;
      default: return 17;
    endcase
  endfunction

  function automatic int word_len(input int idx);
    return (idx == 2) ? 24 : 8;
  endfunction

  function automatic logic [23:0] word_bits(input int idx);
    case (idx)
      0: return 24'h000040;
      1: return 24'h000042;
      default: return 24'h440004;
    endcase
  endfunction
endpackage

// File: rtl/t1pg_word_gen.sv
module t1pg_word_gen #(
  parameter int          W    = 8,
  parameter logic [23:0] WORD = 24'h000040
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic restart,
  output logic bit_o
);
  localparam int PW = (W > 1) ? $clog2(W) : 1;

  logic [PW-1:0] pos;
  logic [PW-1:0] base_pos;

  always_comb base_pos = restart ? '0 : pos;

  assign bit_o = WORD[W - 1 - int'(base_pos)];

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (step) begin
      pos <= (base_pos == PW'(W - 1)) ? '0 : base_pos + 1'b1;
    end
  end

  // R3: the word position never leaves the word
  a_r3_pos_bound: assert property (@(posedge clk) disable iff (rst)
    pos <= PW'(W - 1));
endmodule

// File: rtl/t1pg_lfsr_gen.sv
module t1pg_lfsr_gen #(
  parameter int ORDER = 9,
  parameter int TAP   = 5,
  parameter bit ZSUP  = 1'b0,
  parameter int ZMAX  = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic restart,
  output logic bit_o
);
  localparam int ZW = $clog2(ZMAX + 1);

  logic [ORDER-1:0] state;
  logic [ORDER-1:0] base_state;
  logic [ZW-1:0]    zrun;
  logic [ZW-1:0]    base_run;
  logic             raw;
  logic             force_one;

  always_comb begin
    base_state = restart ? '1 : state;
    base_run   = restart ? '0 : zrun;
    raw        = base_state[ORDER-1];
    force_one  = ZSUP && (base_run == ZW'(ZMAX));
    bit_o      = raw | force_one;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '1;
      zrun  <= '0;
    end else if (step) begin
      state <= {base_state[ORDER-2:0], base_state[ORDER-1] ^ base_state[TAP-1]};
      if (bit_o)
        zrun <= '0;
      else if (base_run != ZW'(ZMAX))
        zrun <= base_run + 1'b1;
      else
        zrun <= base_run;
    end
  end

  // R4: a maximal-length register never reaches the all-zero lock-up state
  a_r4_no_lockup: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  // R5: the zero-run tracker stays within its cap
  a_r5_run_cap: assert property (@(posedge clk) disable iff (rst)
    zrun <= ZW'(ZMAX));
endmodule

// File: rtl/t1pg_user_store.sv
module t1pg_user_store #(
  parameter int SLOTS  = 6,
  parameter int MAXLEN = 24,
  parameter int IW     = 3,
  parameter int LW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [LW-1:0]     wr_len,
  input  logic [MAXLEN-1:0] wr_data,
  input  logic [IW-1:0]     rd_slot,
  input  logic              step,
  input  logic              restart,
  output logic              bit_o
);
  logic [MAXLEN-1:0] data_mem [SLOTS];
  logic [LW-1:0]     len_mem  [SLOTS];
  logic [LW-1:0]     len_clamped;
  logic [MAXLEN-1:0] cur_data;
  logic [LW-1:0]     cur_len;
  logic [LW-1:0]     pos;
  logic [LW-1:0]     base_pos;
  logic              rd_ok;

  always_comb begin
    len_clamped = (wr_len > LW'(MAXLEN - 1)) ? LW'(MAXLEN - 1) : wr_len;
    rd_ok       = int'(rd_slot) < SLOTS;
  end

  // small write-only-indexed memory, no reset, one write port
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_idx) < SLOTS)) begin
      data_mem[wr_idx] <= wr_data;
      len_mem[wr_idx]  <= len_clamped;
    end
  end

  always_comb begin
    cur_data = rd_ok ? data_mem[rd_slot] : '0;
    cur_len  = rd_ok ? len_mem[rd_slot]  : '0;
    base_pos = restart ? '0 : pos;
    if (base_pos <= cur_len)
      bit_o = cur_data[cur_len - base_pos];
    else
      bit_o = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (step) begin
      pos <= (base_pos >= cur_len) ? '0 : base_pos + 1'b1;
    end
  end

  // R8: the playback position never runs past the longest pattern
  a_r8_pos_bound: assert property (@(posedge clk) disable iff (rst)
    pos <= LW'(MAXLEN - 1));
endmodule

// File: rtl/t1_pattern_gen.sv
module t1_pattern_gen
  import t1pg_pkg::*;
#(
  parameter int USER_SLOTS  = 6,
  parameter int USER_MAXLEN = 24,
  localparam int IDX_W = $clog2(USER_SLOTS),
  localparam int LEN_W = $clog2(USER_MAXLEN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bit_en,
  input  logic [SEL_W-1:0]       pat_sel,
  input  logic                   invert,
  input  logic                   up_we,
  input  logic [IDX_W-1:0]       up_idx,
  input  logic [LEN_W-1:0]       up_len,
  input  logic [USER_MAXLEN-1:0] up_data,
  output logic                   bit_out
);
  localparam int USER_LAST = USER_BASE + USER_SLOTS - 1;

  logic [SEL_W-1:0]    sel_q;
  logic                pend;
  logic                restart;
  logic                we_hit;
  logic                is_user;
  logic [IDX_W-1:0]    rd_slot;
  logic [NUM_WORDS-1:0] word_bits_v;
  logic [NUM_LFSR-1:0]  lfsr_bits_v;
  logic                user_bit;
  logic                pat_bit;

  always_comb begin
    restart = pend || (pat_sel != sel_q);
    is_user = (int'(pat_sel) >= USER_BASE) && (int'(pat_sel) <= USER_LAST);
    rd_slot = is_user ? IDX_W'(int'(pat_sel) - USER_BASE) : '0;
    we_hit  = up_we && (int'(up_idx) < USER_SLOTS)
              && (int'(pat_sel) == USER_BASE + int'(up_idx));
  end

  genvar g;
  generate
    for (g = 0; g < NUM_WORDS; g++) begin : g_word
      t1pg_word_gen #(
        .W    (word_len(g)),
        .WORD (word_bits(g))
      ) u_word (
        .clk     (clk),
        .rst     (rst),
        .step    (bit_en && (int'(pat_sel) == CODE_WORD0 + g)),
        .restart (restart),
        .bit_o   (word_bits_v[g])
      );
    end
    for (g = 0; g < NUM_LFSR; g++) begin : g_lfsr
      t1pg_lfsr_gen #(
        .ORDER (lfsr_order(g)),
        .TAP   (lfsr_tap(g)),
        .ZSUP  (g == QRSS_IDX),
        .ZMAX  (QRSS_ZMAX)
      ) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .step    (bit_en && (int'(pat_sel) == CODE_LFSR0 + g)),
        .restart (restart),
        .bit_o   (lfsr_bits_v[g])
      );
    end
  endgenerate

  t1pg_user_store #(
    .SLOTS  (USER_SLOTS),
    .MAXLEN (USER_MAXLEN),
    .IW     (IDX_W),
    .LW     (LEN_W)
  ) u_user (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (up_we),
    .wr_idx  (up_idx),
    .wr_len  (up_len),
    .wr_data (up_data),
    .rd_slot (rd_slot),
    .step    (bit_en && is_user),
    .restart (restart),
    .bit_o   (user_bit)
  );

  always_comb begin
    if (int'(pat_sel) == CODE_ONES)
      pat_bit = 1'b1;
    else if ((int'(pat_sel) >= CODE_WORD0) && (int'(pat_sel) < CODE_WORD0 + NUM_WORDS))
      pat_bit = word_bits_v[int'(pat_sel) - CODE_WORD0];
    else if ((int'(pat_sel) >= CODE_LFSR0) && (int'(pat_sel) < CODE_LFSR0 + NUM_LFSR))
      pat_bit = lfsr_bits_v[int'(pat_sel) - CODE_LFSR0];
    else if (is_user)
      pat_bit = user_bit;
    else
      pat_bit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_out <= 1'b0;
      sel_q   <= '1;
      pend    <= 1'b0;
    end else begin
      if (bit_en) begin
        bit_out <= pat_bit ^ invert;
        sel_q   <= pat_sel;
      end
      if (we_hit)
        pend <= 1'b1;
      else if (bit_en)
        pend <= 1'b0;
    end
  end

  // R9: output holds on clocks without an enable
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(bit_out));

  // R2: the all-ones code yields a one before inversion
  a_r2_ones: assert property (@(posedge clk) disable iff (rst)
    (bit_en && int'(pat_sel) == CODE_ONES) |=> (bit_out == !$past(invert)));

  // R10: a fresh PRBS selection starts with a one
  a_r10_prbs_first: assert property (@(posedge clk) disable iff (rst)
    (bit_en && pat_sel != sel_q && int'(pat_sel) >= CODE_LFSR0
     && int'(pat_sel) < CODE_LFSR0 + NUM_LFSR) |=> (bit_out == !$past(invert)));

  // R12: unassigned codes produce zeros before inversion
  a_r12_unused: assert property (@(posedge clk) disable iff (rst)
    (bit_en && int'(pat_sel) > USER_LAST) |=> (bit_out == $past(invert)));
endmodule

// File: tb/sim_t1_pattern_gen.sv
module sim_t1_pattern_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        bit_en;
  logic [4:0]  pat_sel;
  logic        invert;
  logic        up_we;
  logic [2:0]  up_idx;
  logic [4:0]  up_len;
  logic [23:0] up_data;
  logic        bit_out;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  t1_pattern_gen u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .pat_sel(pat_sel), .invert(invert),
    .up_we(up_we), .up_idx(up_idx), .up_len(up_len), .up_data(up_data),
    .bit_out(bit_out)
  );

  // behavioural reference model
  logic   exp_out;
  int     msel;
  bit     mpend;
  int     k;
  int     zr;
  bit     hist[$];
  int     mlen [6];
  logic [23:0] mdat [6];

  function automatic bit rec_bit(input int n, input int t);
    if (hist.size() < n) return 1'b1;
    return hist[hist.size() - n] ^ hist[hist.size() - t];
  endfunction

  always @(posedge clk) begin
    bit b;
    bit raw;
    int s;
    int ln;
    if (rst) begin
      exp_out = 1'b0; msel = 31; mpend = 0; k = 0; zr = 0; hist.delete();
    end else begin
      if (bit_en) begin
        if (mpend || int'(pat_sel) != msel) begin
          k = 0; zr = 0; hist.delete();
        end
        b = 1'b0;
        case (int'(pat_sel))
          0: b = 1'b0;
          1: b = 1'b1;
          2: b = (8'h40 >> (7 - k % 8)) & 1;
          3: b = (8'h42 >> (7 - k % 8)) & 1;
          4: b = (24'h440004 >> (23 - k % 24)) & 1;
          5, 6, 7, 8, 9, 10: begin
            case (int'(pat_sel))
              5: raw = rec_bit(9, 5);
              6: raw = rec_bit(11, 9);
              7: raw = rec_bit(15, 14);
              8: raw = rec_bit(20, 3);
              9: raw = rec_bit(23, 18);
              default: raw = rec_bit(20, 17);
            endcase
            hist.push_back(raw);
            if (hist.size() > 23) void'(hist.pop_front());
            b = raw;
            if (int'(pat_sel) == 10) begin
              if (zr >= 14) b = 1'b1;
              zr = b ? 0 : zr + 1;
            end
          end
          11, 12, 13, 14, 15, 16: begin
            s  = int'(pat_sel) - 11;
            ln = mlen[s] + 1;
            b  = (mdat[s] >> (ln - 1 - k % ln)) & 1;
          end
          default: b = 1'b0;
        endcase
        k++;
        exp_out = b ^ invert;
        msel = int'(pat_sel);
        mpend = 0;
      end
      if (up_we && up_idx < 6) begin
        if (int'(pat_sel) == 11 + int'(up_idx)) mpend = 1;
        mlen[up_idx] = (up_len > 23) ? 23 : int'(up_len);
        mdat[up_idx] = up_data;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      total++;
      if (bit_out !== exp_out) begin
        bad++;
        $display("FAIL %s t=%0t bit_out=%b expected=%b", phase, $time, bit_out, exp_out);
      end
    end
  end

  task automatic run(input int code, input int n, input bit gated);
    pat_sel = 5'(code);
    for (int i = 0; i < n; i++) begin
      bit_en = gated ? (i % 3 != 0) : 1'b1;
      @(negedge clk);
    end
    bit_en = 1'b0;
  endtask

  task automatic wr(input int idx, input int len, input logic [23:0] d, input bit en);
    up_we = 1'b1; up_idx = 3'(idx); up_len = 5'(len); up_data = d; bit_en = en;
    @(negedge clk);
    up_we = 1'b0; bit_en = 1'b0;
  endtask

  initial begin
    int maxrun;
    int run_z;
    rst = 1'b1; bit_en = 0; pat_sel = 0; invert = 0;
    up_we = 0; up_idx = 0; up_len = 0; up_data = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    phase = "R1";
    total++;
    if (bit_out !== 1'b0) begin
      bad++; $display("FAIL R1 reset bit_out=%b expected=0", bit_out);
    end
    phase = "R2"; run(1, 30, 0); run(0, 30, 0);
    phase = "R6"; invert = 1; run(1, 20, 0); run(0, 20, 0); invert = 0;
    phase = "R3"; run(2, 60, 0); run(3, 60, 0); run(4, 80, 0);
    phase = "R4";
    for (int c = 5; c <= 9; c++) run(c, 600, 0);
    phase = "R6"; pat_sel = 7;
    for (int i = 0; i < 200; i++) begin
      bit_en = 1; invert = (i / 17) % 2; @(negedge clk);
    end
    invert = 0; bit_en = 0;
    phase = "R9"; run(6, 300, 1);
    phase = "R10";
    run(4, 10, 0); run(2, 3, 0); run(4, 5, 1); run(5, 7, 0); run(4, 30, 0);
    phase = "R12"; run(20, 20, 0); run(31, 10, 0);
    phase = "R7";
    wr(0, 0, 24'h000001, 0);
    wr(1, 4, 24'h000016, 0);
    wr(2, 23, 24'hF0C3A5, 0);
    wr(3, 7, 24'h000081, 0);
    wr(4, 12, 24'h001ABC, 0);
    wr(5, 31, 24'h00FFF0, 0);
    wr(6, 3, 24'hFFFFFF, 0);
    wr(7, 9, 24'h123456, 0);
    phase = "R8";
    for (int c = 11; c <= 16; c++) run(c, 70, 0);
    phase = "R11";
    run(15, 6, 0);
    wr(4, 5, 24'h00002D, 1);
    run(15, 20, 0);
    wr(4, 9, 24'h0003C5, 0);
    run(15, 15, 1);
    wr(3, 2, 24'h000005, 1);
    run(15, 12, 0);
    phase = "R5";
    pat_sel = 10; maxrun = 0; run_z = 0;
    for (int i = 0; i < 40000; i++) begin
      bit_en = 1; @(negedge clk);
      run_z = (bit_out == 1'b0) ? run_z + 1 : 0;
      if (run_z > maxrun) maxrun = run_z;
    end
    bit_en = 0;
    total++;
    if (maxrun > 14) begin
      bad++; $display("FAIL R5 longest zero run=%0d expected<=14", maxrun);
    end
    @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog %s bit_out=%b expected=finish", phase, bit_out);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule